// File: doc/BRIEF.md
# Time-Switched Input-Register LUT Element

This block is one array element of a time-multiplexed logic fabric. It holds several 4-input lookup tables. Each table input has its own register, and no register sits on the table output. Each input register has a programmed load time and a programmed source line. A timestep value is broadcast to every register in the element. A register copies its chosen line from the shared input bus only in the cycle where its load time equals the broadcast timestep. At every other step it keeps what it holds.

Because of this, a value can be taken off the interconnect as soon as it arrives and kept until the table evaluates. The wire that carried it is then free for other traffic. Every table output is reported together with a valid flag. The flag goes high once all four inputs of that table have been loaded in the current round. A new round begins at timestep 0.

The timestep advances on a fixed schedule, and there is no back-pressure at either edge of the element. The input lines are sampled only when the schedule says to sample them, and the outputs are plain levels paired with their valid flag. No handshake is needed for that reason. Configuration inputs are treated as static while a schedule runs.

Top module: `tsw_lut_element`

## Requirements
- R1: While `rst_n` is low at a clock edge, every input register and every loaded flag clears. After that edge each `lut_valid` bit is 0, and each `lut_out` bit equals bit 0 of its truth table.
- R2: An input register loads at a clock edge when its 4-bit load time equals `ts`. It takes `in_lines[sel]`, where `sel` is its 3-bit source select and picks one of the eight shared lines by index.
- R3: An input register whose load time differs from `ts` keeps its value across the edge, whatever `in_lines` carries.
- R4: `lut_out[l]` equals bit `idx` of the 16-bit truth table of LUT l. Here `idx` is formed from the four registered inputs, with input 0 as the least significant bit. The output follows the registers without a further register stage.
- R5: `lut_valid[l]` is 1 exactly when each of the four input registers of LUT l has loaded at some edge since the most recent edge with `ts` = 0, counting that edge itself. An edge with `ts` = 0 clears any load made before it.
- R6: If `ts` stays equal to a register's load time for several cycles, that register reloads at every one of those edges and follows the selected line.
- R7: Configuration in slot l·4+k (load time bits [4(l·4+k)+3 : 4(l·4+k)], select bits [3(l·4+k)+2 : 3(l·4+k)]) controls only input k of LUT l. Truth table bits [16l+15 : 16l] control only LUT l.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ts | input | 4 | Broadcast current timestep |
| in_lines | input | 8 | Shared element input lines |
| cfg_load_time | input | 64 | Load time per input register, 4 bits per slot |
| cfg_src_sel | input | 48 | Source line select per input register, 3 bits per slot |
| cfg_truth | input | 64 | Truth table per LUT, 16 bits each |
| lut_out | output | 4 | LUT outputs |
| lut_valid | output | 4 | All inputs of the LUT loaded this round |

## Verification
The valid flag is the hardest behaviour to reach from the ports. It needs four independent load times per LUT to line up with a wrapping timestep. It also has to be re-armed at step 0, and a load that lands exactly on step 0 has to count toward the new round. The stimulus randomizes the load times and the wrap point for each configuration. It also runs long stretches with the timestep frozen on one value, and it compares every output against a behavioural model on every cycle. Load times beyond the wrap point give LUTs that never become valid. Load times of 0 exercise the edge that both clears the round and loads a register.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int LUT_K = 4;
  localparam int TT_W  = 1 << LUT_K;
  localparam int TS_W  = 4;
endpackage

// File: rtl/tsw_input_reg.sv
module tsw_input_reg #(
  parameter int N_LINE = 8,
  parameter int TS_W   = 4,
  localparam int SEL_W = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   ts,
  input  logic [N_LINE-1:0] lines,
  input  logic [TS_W-1:0]   load_time,
  input  logic [SEL_W-1:0]  src_sel,
  output logic              q,
  output logic              loaded
);
  logic hit;
  logic picked;
  logic round_start;

  assign hit         = (ts == load_time);
  assign picked      = lines[src_sel];
  assign round_start = (ts == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q      <= 1'b0;
      loaded <= 1'b0;
    end else begin
      if (hit) q <= picked;
      loaded <= hit | (loaded & ~round_start);
    end
  end

  AST_HOLD_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(q)); // R3
  AST_LOAD_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> q == $past(lines[src_sel])); // R2
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> loaded); // R5
endmodule

// File: rtl/tsw_lut4.sv
module tsw_lut4
  import tsw_pkg::*;
#(
  parameter int N_LINE = 8,
  parameter int TS_W_P = TS_W,
  localparam int SEL_W = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TS_W_P-1:0]       ts,
  input  logic [N_LINE-1:0]       lines,
  input  logic [LUT_K*TS_W_P-1:0] load_times,
  input  logic [LUT_K*SEL_W-1:0]  src_sels,
  input  logic [TT_W-1:0]         truth,
  output logic                    out,
  output logic                    valid
);
  logic [LUT_K-1:0] idx;
  logic [LUT_K-1:0] flags;
  logic [LUT_K-1:0] hits;

  for (genvar k = 0; k < LUT_K; k++) begin : g_in
    tsw_input_reg #(.N_LINE(N_LINE), .TS_W(TS_W_P)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .ts        (ts),
      .lines     (lines),
      .load_time (load_times[k*TS_W_P +: TS_W_P]),
      .src_sel   (src_sels[k*SEL_W +: SEL_W]),
      .q         (idx[k]),
      .loaded    (flags[k])
    );
    assign hits[k] = (ts == load_times[k*TS_W_P +: TS_W_P]);
  end

  assign out   = truth[idx];
  assign valid = &flags;

  AST_ROSE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(|hits)); // R5
  AST_ROUND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == '0 && hits != {LUT_K{1'b1}}) |=> !valid); // R5
endmodule

// File: rtl/tsw_lut_element.sv
module tsw_lut_element
  import tsw_pkg::*;
#(
  parameter int N_LUT  = 4,
  parameter int N_LINE = 8,
  localparam int SEL_W = (N_LINE > 1) ? $clog2(N_LINE) : 1,
  localparam int N_REG = N_LUT * LUT_K
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TS_W-1:0]        ts,
  input  logic [N_LINE-1:0]      in_lines,
  input  logic [N_REG*TS_W-1:0]  cfg_load_time,
  input  logic [N_REG*SEL_W-1:0] cfg_src_sel,
  input  logic [N_LUT*TT_W-1:0]  cfg_truth,
  output logic [N_LUT-1:0]       lut_out,
  output logic [N_LUT-1:0]       lut_valid
);
  for (genvar l = 0; l < N_LUT; l++) begin : g_lut
    tsw_lut4 #(.N_LINE(N_LINE), .TS_W_P(TS_W)) u_lut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ts         (ts),
      .lines      (in_lines),
      .load_times (cfg_load_time[l*LUT_K*TS_W +: LUT_K*TS_W]),
      .src_sels   (cfg_src_sel[l*LUT_K*SEL_W +: LUT_K*SEL_W]),
      .truth      (cfg_truth[l*TT_W +: TT_W]),
      .out        (lut_out[l]),
      .valid      (lut_valid[l])
    );
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> lut_valid == '0); // R1
endmodule

// File: tb/tb_tsw_lut_element.sv
module tb_tsw_lut_element;
  localparam int NL = 4;
  localparam int NK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ts = '0;
  logic [7:0]  in_lines = '0;
  logic [63:0] cfg_load_time = '0;
  logic [47:0] cfg_src_sel = '0;
  logic [63:0] cfg_truth = '0;
  logic [3:0]  lut_out;
  logic [3:0]  lut_valid;

  int checks = 0;
  int fails = 0;
  int mq [NL][NK];
  int mf [NL][NK];

  always #2.5 clk = ~clk;

  tsw_lut_element dut (
    .clk(clk), .rst_n(rst_n), .ts(ts), .in_lines(in_lines),
    .cfg_load_time(cfg_load_time), .cfg_src_sel(cfg_src_sel),
    .cfg_truth(cfg_truth), .lut_out(lut_out), .lut_valid(lut_valid)
  );

  // behavioural reference, updated on each edge
  always @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      for (int k = 0; k < NK; k++) begin
        int slot;
        int lt;
        int sel;
        slot = l * NK + k;
        lt = int'(cfg_load_time[slot*4 +: 4]);
        sel = int'(cfg_src_sel[slot*3 +: 3]);
        if (!rst_n) begin
          mq[l][k] = 0;
          mf[l][k] = 0;
        end else begin
          if (int'(ts) == lt) begin
            mq[l][k] = int'(in_lines[sel]);
            mf[l][k] = 1;
          end else if (ts == 0) begin
            mf[l][k] = 0;
          end
        end
      end
    end
  end

  task automatic compare(input string tag);
    for (int l = 0; l < NL; l++) begin
      int idx;
      int allf;
      logic eo;
      idx = 0;
      allf = 1;
      for (int k = 0; k < NK; k++) begin
        idx += mq[l][k] << k;
        if (mf[l][k] == 0) allf = 0;
      end
      eo = cfg_truth[l*16 + idx];
      checks++;
      if (lut_out[l] !== eo) begin
        fails++;
        $display("FAIL %s R4 lut_out[%0d] actual=%b expected=%b", tag, l, lut_out[l], eo);
      end
      checks++;
      if (lut_valid[l] !== allf[0]) begin
        fails++;
        $display("FAIL %s R5 lut_valid[%0d] actual=%b expected=%b", tag, l, lut_valid[l], allf[0]);
      end
    end
  endtask

  task automatic randomize_cfg(input int max_lt);
    for (int s = 0; s < NL * NK; s++) begin
      cfg_load_time[s*4 +: 4] = 4'($urandom_range(max_lt, 0));
      cfg_src_sel[s*3 +: 3] = 3'($urandom_range(7, 0));
    end
    for (int l = 0; l < NL; l++) cfg_truth[l*16 +: 16] = 16'($urandom);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none

    // R1: reset state
    cfg_truth = {16'h0001, 16'hFFFE, 16'h0001, 16'h8001};
    randomize_cfg(15);
    cfg_truth = {16'h0001, 16'hFFFE, 16'h0001, 16'h8001};
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      checks++;
      if (lut_valid[l] !== 1'b0 || lut_out[l] !== cfg_truth[l*16]) begin
        fails++;
        $display("FAIL R1 lut %0d actual=%b/%b expected=0/%b", l, lut_valid[l], lut_out[l], cfg_truth[l*16]);
      end
    end
    compare("R1");
    rst_n = 1'b1;

    // R2 R3 R4 R5 R7: random configs with wrapping timestep
    for (int c = 0; c < 24; c++) begin
      int last;
      last = $urandom_range(15, 3);
      randomize_cfg(c % 3 == 0 ? 15 : last);
      ts = 4'd0;
      for (int t = 0; t < 50; t++) begin
        in_lines = 8'($urandom);
        @(posedge clk);
        @(negedge clk);
        compare("R2 R3 R7 sweep");
        ts = (int'(ts) >= last) ? 4'd0 : ts + 4'd1;
      end
    end

    // R6: timestep frozen on a load time, lines changing
    randomize_cfg(3);
    for (int h = 0; h < 4; h++) begin
      ts = 4'(h);
      for (int t = 0; t < 12; t++) begin
        in_lines = 8'($urandom);
        @(posedge clk);
        @(negedge clk);
        compare("R6 frozen step");
      end
    end

    // R1 again: reset mid-run
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare("R1 mid-run reset");
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule